// File: doc/BRIEF.md
# Timebase Interval Timer

This block is a free-running binary prescaler that always counts the main clock. It gives out one-clock carry pulses at four bit positions of the count, and a watchdog or other slow logic can use any of them as a time step. One of the four pulses is chosen through a 2-bit interval field. Each time the chosen pulse fires, a sticky overflow flag is set. The interrupt request is that flag gated by an enable bit.

Software uses a single 8-bit control register. Bit 4 is the interrupt enable. Bit 3 is the overflow flag, which a written 0 clears. Bit 2 is a command bit: writing 0 to it restarts the prescaler from zero. Bits 1:0 select the interval. Bit 7 always reads 1, bits 6:5 always read 0, and bit 2 always reads 1. By default the taps sit at 2^12, 2^14, 2^16 and 2^19 clocks, so the counter is 19 bits wide. Each tap position is a parameter.

Top module: `tbt_timebase`

## Requirements
- R1: While `rst` is high and directly after it, `rd_data` reads 8'h84: enable 0, flag 0, interval 00, with the fixed bits set. `irq` and `tap_o` are 0.
- R2: Tap k (periods P_k = 2^TAP_k) pulses for exactly one clock. The pulse comes every P_k clocks. The first pulse is P_k clocks after the count starts from zero.
- R3: The interval field `rd_data[1:0]` (00, 01, 10, 11) picks tap 0, 1, 2 or 3. The flag `rd_data[3]` goes high on the clock edge that follows a pulse of the selected tap.
- R4: `irq` is high exactly when both the flag and the enable bit `rd_data[4]` are high. A flag set while the enable bit is 0 gives no request.
- R5: A write with `wr_data[3]`=0 clears the flag. A write with `wr_data[3]`=1 leaves it as it is. If the selected tap pulses in the same cycle as a clearing write, the flag stays set.
- R6: A write with `wr_data[2]`=0 clears the prescaler and any pending tap pulse. Every tap then next fires P_k clocks after that write edge. A write with `wr_data[2]`=1 does not disturb the count.
- R7: `rd_data[7]` and `rd_data[2]` always read 1, and `rd_data[6:5]` always read 0, whatever is written.
- R8: Taps are nested. Whenever a longer tap pulses, every shorter tap pulses in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Write data for the control register |
| rd_data | output | 8 | Current control register value |
| irq | output | 1 | Interval interrupt request |
| tap_o | output | 4 | One-clock carry pulses of taps 0..3 |

## Verification
The interval path is exercised with all four interval settings, and each one runs two back-to-back periods after a restart. This shows that the selector picks the right tap and that clearing the flag does not disturb the count. A cycle-by-cycle sweep of the raw taps after a restart separates the period of each tap from the nesting of the shorter taps inside the longer ones. A run with the enable bit off, followed by setting the enable bit, tells masking apart from flag setting. A clearing write placed on the very cycle of a tap pulse, then one placed a cycle later, separates the set-wins priority from a plain clear.

// File: rtl/tbt_pkg.sv
package tbt_pkg;
  localparam int unsigned REG_W   = 8;
  localparam int unsigned NUM_TAP = 4;
  localparam int unsigned SEL_W   = $clog2(NUM_TAP);

  localparam int unsigned B_FIXED = 7;
  localparam int unsigned B_IE    = 4;
  localparam int unsigned B_FLAG  = 3;
  localparam int unsigned B_CLR   = 2;

  typedef struct packed {
    logic             ie;
    logic             flag;
    logic [SEL_W-1:0] sel;
  } tbt_ctrl_t;

  function automatic logic [REG_W-1:0] tbt_read(input tbt_ctrl_t c);
    logic [REG_W-1:0] w;
    w             = '0;
    w[B_FIXED]    = 1'b1;
    w[B_IE]       = c.ie;
    w[B_FLAG]     = c.flag;
    w[B_CLR]      = 1'b1;
    w[SEL_W-1:0]  = c.sel;
    return w;
  endfunction
endpackage

// File: rtl/tbt_prescaler.sv
module tbt_prescaler #(
  parameter int unsigned TAP_0 = 12,
  parameter int unsigned TAP_1 = 14,
  parameter int unsigned TAP_2 = 16,
  parameter int unsigned TAP_3 = 19,
  localparam int unsigned CNT_W = TAP_3
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        clr,
  output logic [tbt_pkg::NUM_TAP-1:0] tap_o
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else            cnt <= cnt + 1'b1;
  end

  for (genvar k = 0; k < int'(tbt_pkg::NUM_TAP); k++) begin : g_tap
    localparam int unsigned TW = (k == 0) ? TAP_0 :
                                 (k == 1) ? TAP_1 :
                                 (k == 2) ? TAP_2 : TAP_3;
    logic q;
    // pulse in the cycle after the low TW bits roll over to zero
    always_ff @(posedge clk) begin
      if (rst || clr) q <= 1'b0;
      else            q <= &cnt[TW-1:0];
    end
    assign tap_o[k] = q;
  end
endmodule

// File: rtl/tbt_tap_sel.sv
module tbt_tap_sel (
  input  logic [tbt_pkg::NUM_TAP-1:0] taps,
  input  logic [tbt_pkg::SEL_W-1:0]   sel,
  output logic                        hit
);
  always_comb hit = taps[sel];
endmodule

// File: rtl/tbt_ctrl.sv
module tbt_ctrl
  import tbt_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      wr_en,
  input  logic      wr_ie,
  input  logic      wr_flag,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic      hit,
  output tbt_ctrl_t ctrl
);
  tbt_ctrl_t nxt;

  always_comb begin
    nxt = ctrl;
    if (wr_en) begin
      nxt.ie  = wr_ie;
      nxt.sel = wr_sel;
      if (!wr_flag) nxt.flag = 1'b0;
    end
    if (hit) nxt.flag = 1'b1;   // a carry beats a software clear
  end

  always_ff @(posedge clk) begin
    if (rst) ctrl <= '0;
    else     ctrl <= nxt;
  end
endmodule

// File: rtl/tbt_timebase.sv
module tbt_timebase
  import tbt_pkg::*;
#(
  parameter int unsigned TAP_0 = 12,
  parameter int unsigned TAP_1 = 14,
  parameter int unsigned TAP_2 = 16,
  parameter int unsigned TAP_3 = 19
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [REG_W-1:0]   wr_data,
  output logic [REG_W-1:0]   rd_data,
  output logic               irq,
  output logic [NUM_TAP-1:0] tap_o
);
  tbt_ctrl_t ctrl;
  logic      clr_cmd;
  logic      hit;
  logic      unused_bits;

  assign unused_bits = ^wr_data[REG_W-1:B_IE+1];
  assign clr_cmd     = wr_en && !wr_data[B_CLR];

  tbt_prescaler #(
    .TAP_0(TAP_0), .TAP_1(TAP_1), .TAP_2(TAP_2), .TAP_3(TAP_3)
  ) u_pre (
    .clk(clk), .rst(rst), .clr(clr_cmd), .tap_o(tap_o)
  );

  tbt_tap_sel u_sel (
    .taps(tap_o), .sel(ctrl.sel), .hit(hit)
  );

  tbt_ctrl u_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en),
    .wr_ie(wr_data[B_IE]), .wr_flag(wr_data[B_FLAG]),
    .wr_sel(wr_data[SEL_W-1:0]), .hit(hit), .ctrl(ctrl)
  );

  assign rd_data = tbt_read(ctrl);
  assign irq     = ctrl.flag && ctrl.ie;
endmodule

// File: rtl/tbt_timebase_chk.sv
module tbt_timebase_chk (
  input logic       clk,
  input logic       rst,
  input logic       wr_en,
  input logic       wr_flag,
  input logic       wr_clr,
  input logic [7:0] rd_data,
  input logic       irq,
  input logic [3:0] tap_o
);
  for (genvar k = 0; k < 4; k++) begin : g_single
    a_r2_single_pulse: assert property (@(posedge clk) disable iff (rst)
      tap_o[k] |=> !tap_o[k]);
  end

  for (genvar k = 1; k < 4; k++) begin : g_nest
    a_r8_nested: assert property (@(posedge clk) disable iff (rst)
      tap_o[k] |-> tap_o[k-1]);
  end

  a_r3_flag_source: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_data[3]) |-> $past(tap_o[rd_data[1:0]]));

  a_r4_irq_gate: assert property (@(posedge clk) disable iff (rst)
    irq |-> (rd_data[4] && rd_data[3]));

  a_r5_clear: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_flag && !tap_o[rd_data[1:0]]) |=> !rd_data[3]);

  a_r5_carry_wins: assert property (@(posedge clk) disable iff (rst)
    tap_o[rd_data[1:0]] |=> rd_data[3]);

  a_r6_restart: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_clr) |=> (tap_o == 4'b0000));

  a_r7_fixed_bits: assert property (@(posedge clk) disable iff (rst)
    rd_data[7] && rd_data[2] && (rd_data[6:5] == 2'b00));
endmodule

bind tbt_timebase tbt_timebase_chk u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en),
  .wr_flag(wr_data[3]), .wr_clr(wr_data[2]),
  .rd_data(rd_data), .irq(irq), .tap_o(tap_o)
);

// File: tb/tbt_timebase_test.sv
module tbt_timebase_test;
  localparam int T0 = 3, T1 = 4, T2 = 5, T3 = 7;
  localparam int WD_LIMIT = 5000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       irq;
  logic [3:0] tap_o;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  int periods [4] = '{1 << T0, 1 << T1, 1 << T2, 1 << T3};
  int    exp_q [$];
  string req_q [$];
  logic  irq_prev = 1'b0;
  bit    done = 1'b0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  tbt_timebase #(.TAP_0(T0), .TAP_1(T1), .TAP_2(T2), .TAP_3(T3)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .irq(irq), .tap_o(tap_o)
  );

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h (cycle %0d)", req, got, exp, cyc);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic expect_irq(input int at, input string req);
    exp_q.push_back(at);
    req_q.push_back(req);
  endtask

  task automatic wait_irq();
    while (!irq) @(negedge clk);
  endtask

  // monitor: every rising edge of irq must match the front of the queue
  always @(negedge clk) begin
    if (!rst) begin
      if (irq && !irq_prev) begin
        if (exp_q.size() == 0) check("R4 unexpected irq", cyc, -1);
        else check(req_q.pop_front(), cyc, exp_q.pop_front());
      end
      irq_prev = irq;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 rd_data", rd_data, 8'h84);
    check("R1 irq", irq, 0);
    check("R1 tap_o", tap_o, 0);

    // R7: fixed bits ignore the written value
    wr(8'hFF);
    check("R7 read after FF", rd_data, 8'h97);
    wr(8'h00);
    check("R7 read after 00", rd_data, 8'h84);

    // R2/R8/R6: tap sweep after a restart
    wr(8'h00);
    for (int i = 1; i <= 130; i++) begin
      logic [3:0] e;
      @(negedge clk);
      for (int k = 0; k < 4; k++) e[k] = (i % periods[k]) == 0;
      check("R2 R8 R6 tap pattern", tap_o, e);
    end

    // R3/R6: two periods for every interval setting
    for (int s = 0; s < 4; s++) begin
      int c;
      c = cyc;
      expect_irq(c + periods[s] + 2,     "R3 first period");
      expect_irq(c + 2 * periods[s] + 2, "R3 second period");
      wr(8'h10 | 8'(s));
      wait_irq();
      wr(8'h14 | 8'(s));
      wait_irq();
      wr(8'h04);
    end

    // R4: flag without enable gives no request, enabling raises it
    wr(8'h00);
    repeat (10) @(negedge clk);
    check("R4 masked irq", irq, 0);
    check("R3 flag set while masked", rd_data[3], 1);
    expect_irq(cyc + 1, "R4 enable raises irq");
    wr(8'h1C);
    check("R5 write 1 keeps flag", rd_data[3], 1);
    check("R4 irq with enable", irq, 1);
    wr(8'h04);
    check("R4 irq after disable", irq, 0);

    // R5: clear on the tap cycle loses to the carry
    wr(8'h00);
    repeat (8) @(negedge clk);
    check("R2 tap0 after restart", tap_o[0], 1);
    check("R3 flag not yet set", rd_data[3], 0);
    wr(8'h04);
    check("R5 carry wins over clear", rd_data[3], 1);
    wr(8'h04);
    check("R5 plain clear", rd_data[3], 0);

    repeat (4) @(negedge clk);
    check("R3 no missing irq", exp_q.size(), 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    while (cyc < WD_LIMIT) @(negedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got cycle %0d expected finish", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule